// File: doc/BRIEF.md
# Vectored Prioritised Interrupt Controller

This block collects interrupt requests from hardware lines and from a software-writable request register, then steers each request to one of two outputs. A source whose class bit is set drives the fast-interrupt output `fiq_o`. A source whose class bit is clear joins the normal class. Normal requests are arbitrated in hardware. Up to sixteen numbered vector slots each bind one source to a handler address. A bound request always beats an unbound one, and a lower slot number beats a higher one. Unbound normal requests share the default handler address at the lowest level.

Software sees the winner's handler address when it reads the vector register. That read starts a service: the block records the winner's priority level and address. From then on, `irq_o` rises only for a request of strictly higher priority. A write to the vector register, whatever the data, ends the service and rearms the arbitration. The block does not clear a request at its origin. A level request that is still high is therefore presented again after the acknowledge.

A small state machine tracks the service. It has two states, IDLE and SERVICE. The transitions are:
- IDLE to SERVICE on a vector read while an eligible winner exists.
- SERVICE to SERVICE on a vector read while a strictly higher winner exists. This records the new level and address.
- IDLE or SERVICE to IDLE on any vector write. A write takes precedence over a read in the same cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register is zero and the machine is in IDLE. Both `irq_o` and `fiq_o` are low, and a vector read returns 0.
- R2: The raw request is `irq_src_i` OR the software request register, and it reads at offset 0x00. The enabled normal requests read at 0x01 and the enabled fast requests read at 0x02 (bit n is source n).
- R3: A write to 0x04 sets the enable bits where the data is 1, and a write to 0x05 clears them where the data is 1. Reading either offset returns the enable register. A disabled source changes neither output nor any masked status.
- R4: The class register sits at 0x03 (bit set means fast). `fiq_o` is high when any enabled fast request is present. `fiq_o` is not affected by arbitration or by the service state, and it may be high together with `irq_o`.
- R5: A write to 0x06 sets software request bits where the data is 1, and a write to 0x07 clears them where the data is 1. A 0 in the data leaves the bit unchanged. Both offsets read back the software register.
- R6: Slot i has its handler address at 0x40+i and its control at 0x80+i. In the control word, bit 5 enables the slot and bits 4:0 give the bound source. The default handler address is at 0x09. All of these read back what was written.
- R7: When several enabled slots have a pending normal request, the slot with the lowest number wins and its address is returned by a vector read at 0x08.
- R8: A pending normal request that no enabled slot binds is a default request. It wins only when no slot request is pending, and the vector read then returns the default address.
- R9: In IDLE, `irq_o` is high exactly when a normal request is pending, whether bound or default.
- R10: A vector read with an eligible winner enters SERVICE and records the winner's level and address. In SERVICE, `irq_o` is high only for a strictly higher priority request. With no such request, a vector read returns the recorded address.
- R11: Any write to 0x08 returns the machine to IDLE, and the data value is ignored. A request still asserted at its source raises `irq_o` again right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 32 | Raw hardware request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (vector reads have side effects) |
| bus_addr_i | input | 8 | Register word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Normal-class interrupt request |
| fiq_o | output | 1 | Fast-class interrupt request |

## Verification
A wrong service level or state shows on `irq_o` in the same cycle, because the output is combinational from the ceiling. A ceiling that is too high hides a pre-empting request, and a ceiling that is too low re-raises the request being serviced. A wrong recorded address or a wrong arbitration result shows in the data of the next vector read. The random phase issues vector reads and acknowledges often, so a divergence is seen within a few bus operations. Register faults show in read-back and in the outputs on the next comparison.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] REG_RAW       = 8'h00;
    localparam logic [BUS_AW-1:0] REG_NORM      = 8'h01;
    localparam logic [BUS_AW-1:0] REG_FAST      = 8'h02;
    localparam logic [BUS_AW-1:0] REG_CLASS     = 8'h03;
    localparam logic [BUS_AW-1:0] REG_EN_SET    = 8'h04;
    localparam logic [BUS_AW-1:0] REG_EN_CLR    = 8'h05;
    localparam logic [BUS_AW-1:0] REG_SOFT_SET  = 8'h06;
    localparam logic [BUS_AW-1:0] REG_SOFT_CLR  = 8'h07;
    localparam logic [BUS_AW-1:0] REG_VECTOR    = 8'h08;
    localparam logic [BUS_AW-1:0] REG_DEFAULT   = 8'h09;
    localparam logic [BUS_AW-1:0] SLOT_ADDR_BASE = 8'h40;
    localparam logic [BUS_AW-1:0] SLOT_CTRL_BASE = 8'h80;

    typedef enum logic [0:0] {
        SV_IDLE    = 1'b0,
        SV_SERVICE = 1'b1
    } svc_state_t;

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_SLOT = 16,
    parameter int DW     = 32,
    localparam int SIDX_W = $clog2(N_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic [BUS_AW-1:0]               bus_addr,
    input  logic [DW-1:0]                   bus_wdata,
    input  logic [N_SRC-1:0]                raw_req,
    input  logic [N_SRC-1:0]                norm_req,
    input  logic [N_SRC-1:0]                fast_req,
    input  logic [DW-1:0]                   vec_rdata,
    output logic [DW-1:0]                   bus_rdata,
    output logic [N_SRC-1:0]                en_q,
    output logic [N_SRC-1:0]                class_q,
    output logic [N_SRC-1:0]                soft_q,
    output logic [DW-1:0]                   def_addr_q,
    output logic [N_SLOT-1:0]               slot_en_q,
    output logic [N_SLOT-1:0][SIDX_W-1:0]   slot_src_q,
    output logic [N_SLOT-1:0][DW-1:0]       slot_addr_q
);

    logic [N_SRC-1:0] wbits;
    assign wbits = bus_wdata[N_SRC-1:0];

    function automatic logic [DW-1:0] zext(input logic [N_SRC-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[N_SRC-1:0] = v;
        return r;
    endfunction

    // Global registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            class_q    <= '0;
            soft_q     <= '0;
            def_addr_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                REG_CLASS:    class_q    <= wbits;
                REG_EN_SET:   en_q       <= en_q | wbits;
                REG_EN_CLR:   en_q       <= en_q & ~wbits;
                REG_SOFT_SET: soft_q     <= soft_q | wbits;
                REG_SOFT_CLR: soft_q     <= soft_q & ~wbits;
                REG_DEFAULT:  def_addr_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Per-slot registers
    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_en_q[g]   <= 1'b0;
                slot_src_q[g]  <= '0;
                slot_addr_q[g] <= '0;
            end else if (bus_wr) begin
                if (bus_addr == SLOT_ADDR_BASE + BUS_AW'(g)) begin
                    slot_addr_q[g] <= bus_wdata;
                end
                if (bus_addr == SLOT_CTRL_BASE + BUS_AW'(g)) begin
                    slot_en_q[g]  <= bus_wdata[SIDX_W];
                    slot_src_q[g] <= bus_wdata[SIDX_W-1:0];
                end
            end
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_RAW:      bus_rdata = zext(raw_req);
            REG_NORM:     bus_rdata = zext(norm_req);
            REG_FAST:     bus_rdata = zext(fast_req);
            REG_CLASS:    bus_rdata = zext(class_q);
            REG_EN_SET,
            REG_EN_CLR:   bus_rdata = zext(en_q);
            REG_SOFT_SET,
            REG_SOFT_CLR: bus_rdata = zext(soft_q);
            REG_VECTOR:   bus_rdata = vec_rdata;
            REG_DEFAULT:  bus_rdata = def_addr_q;
            default: begin
                for (int i = 0; i < N_SLOT; i++) begin
                    if (bus_addr == SLOT_ADDR_BASE + BUS_AW'(i)) begin
                        bus_rdata = slot_addr_q[i];
                    end
                    if (bus_addr == SLOT_CTRL_BASE + BUS_AW'(i)) begin
                        bus_rdata[SIDX_W]     = slot_en_q[i];
                        bus_rdata[SIDX_W-1:0] = slot_src_q[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int N_SRC  = 32,
    parameter int N_SLOT = 16,
    parameter int DW     = 32,
    localparam int SIDX_W = $clog2(N_SRC),
    localparam int LVL_W  = $clog2(N_SLOT + 2)
) (
    input  logic [N_SRC-1:0]                norm_req,
    input  logic [N_SLOT-1:0]               slot_en,
    input  logic [N_SLOT-1:0][SIDX_W-1:0]   slot_src,
    input  logic [N_SLOT-1:0][DW-1:0]       slot_addr,
    input  logic [DW-1:0]                   def_addr,
    output logic [LVL_W-1:0]                win_lvl,
    output logic [DW-1:0]                   win_addr
);

    localparam logic [LVL_W-1:0] LVL_DEF  = LVL_W'(N_SLOT);
    localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(N_SLOT + 1);

    logic [N_SLOT-1:0] slot_hit;
    logic [N_SRC-1:0]  bound;
    logic              def_pend;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_hit
        assign slot_hit[g] = slot_en[g] & norm_req[slot_src[g]];
    end

    // Sources claimed by any enabled slot never use the default vector
    always_comb begin
        bound = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (slot_en[i]) begin
                bound[slot_src[i]] = 1'b1;
            end
        end
    end

    assign def_pend = |(norm_req & ~bound);

    // Fixed priority: scan from lowest priority upward so slot 0 wins last
    always_comb begin
        win_lvl  = def_pend ? LVL_DEF : LVL_NONE;
        win_addr = def_addr;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                win_lvl  = LVL_W'(i);
                win_addr = slot_addr[i];
            end
        end
    end

endmodule

// File: rtl/pic_svc_fsm.sv
module pic_svc_fsm
    import pic_pkg::*;
#(
    parameter int N_SLOT = 16,
    parameter int DW     = 32,
    localparam int LVL_W = $clog2(N_SLOT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_rd,
    input  logic              vec_wr,
    input  logic [LVL_W-1:0]  win_lvl,
    input  logic [DW-1:0]     win_addr,
    input  logic [DW-1:0]     def_addr,
    output logic              irq,
    output logic [DW-1:0]     vec_rdata,
    output svc_state_t        state_q,
    output logic [LVL_W-1:0]  svc_lvl_q
);

    localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(N_SLOT + 1);

    svc_state_t       state_d;
    logic [DW-1:0]    svc_addr_q;
    logic [LVL_W-1:0] ceiling;
    logic             eligible;
    logic             capture;

    assign ceiling  = (state_q == SV_SERVICE) ? svc_lvl_q : LVL_NONE;
    assign eligible = win_lvl < ceiling;
    assign capture  = vec_rd && !vec_wr && eligible;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_IDLE: begin
                if (capture) state_d = SV_SERVICE;
            end
            SV_SERVICE: begin
                if (vec_wr) state_d = SV_IDLE;
            end
        endcase
    end

    // Recorded service level and address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_lvl_q  <= LVL_NONE;
            svc_addr_q <= '0;
        end else if (capture) begin
            svc_lvl_q  <= win_lvl;
            svc_addr_q <= win_addr;
        end
    end

    // Outputs
    always_comb begin
        irq = eligible;
        unique case (state_q)
            SV_IDLE:    vec_rdata = eligible ? win_addr : def_addr;
            SV_SERVICE: vec_rdata = eligible ? win_addr : svc_addr_q;
        endcase
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_SLOT = 16,
    parameter int DW     = 32,
    localparam int SIDX_W = $clog2(N_SRC),
    localparam int LVL_W  = $clog2(N_SLOT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [N_SRC-1:0]              en_q, class_q, soft_q;
    logic [N_SRC-1:0]              raw_req, norm_req, fast_req;
    logic [DW-1:0]                 def_addr_q, vec_rdata, win_addr;
    logic [N_SLOT-1:0]             slot_en_q;
    logic [N_SLOT-1:0][SIDX_W-1:0] slot_src_q;
    logic [N_SLOT-1:0][DW-1:0]     slot_addr_q;
    logic [LVL_W-1:0]              win_lvl, svc_lvl;
    logic                          vec_rd, vec_wr;
    svc_state_t                    svc_state;

    assign raw_req  = irq_src_i | soft_q;
    assign norm_req = raw_req & en_q & ~class_q;
    assign fast_req = raw_req & en_q & class_q;
    assign fiq_o    = |fast_req;

    assign vec_rd = bus_rd_i && (bus_addr_i == REG_VECTOR);
    assign vec_wr = bus_wr_i && (bus_addr_i == REG_VECTOR);

    pic_regs #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr_i),
        .bus_addr   (bus_addr_i),
        .bus_wdata  (bus_wdata_i),
        .raw_req    (raw_req),
        .norm_req   (norm_req),
        .fast_req   (fast_req),
        .vec_rdata  (vec_rdata),
        .bus_rdata  (bus_rdata_o),
        .en_q       (en_q),
        .class_q    (class_q),
        .soft_q     (soft_q),
        .def_addr_q (def_addr_q),
        .slot_en_q  (slot_en_q),
        .slot_src_q (slot_src_q),
        .slot_addr_q(slot_addr_q)
    );

    pic_arbiter #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW)) u_arb (
        .norm_req (norm_req),
        .slot_en  (slot_en_q),
        .slot_src (slot_src_q),
        .slot_addr(slot_addr_q),
        .def_addr (def_addr_q),
        .win_lvl  (win_lvl),
        .win_addr (win_addr)
    );

    pic_svc_fsm #(.N_SLOT(N_SLOT), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vec_rd   (vec_rd),
        .vec_wr   (vec_wr),
        .win_lvl  (win_lvl),
        .win_addr (win_addr),
        .def_addr (def_addr_q),
        .irq      (irq_o),
        .vec_rdata(vec_rdata),
        .state_q  (svc_state),
        .svc_lvl_q(svc_lvl)
    );

endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int DW    = 32,
    parameter int LVL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [BUS_AW-1:0] bus_addr_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic              irq_o,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  soft_q,
    input svc_state_t        svc_state,
    input logic [LVL_W-1:0]  svc_lvl,
    input logic [LVL_W-1:0]  win_lvl
);

    a_r5_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == REG_SOFT_CLR)
        |=> ((soft_q & $past(bus_wdata_i[N_SRC-1:0])) == '0));

    a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == REG_EN_SET)
        |=> ((en_q & $past(bus_wdata_i[N_SRC-1:0])) == $past(bus_wdata_i[N_SRC-1:0])));

    a_r11_ack_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == REG_VECTOR) |=> (svc_state == SV_IDLE));

    a_r10_read_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !bus_wr_i && bus_addr_i == REG_VECTOR && irq_o)
        |=> (svc_state == SV_SERVICE));

    a_r10_strict_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_state == SV_SERVICE && irq_o) |-> (win_lvl < svc_lvl));

endmodule

bind prio_irq_ctrl pic_checker #(.N_SRC(N_SRC), .DW(DW), .LVL_W(LVL_W)) u_pic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .irq_o      (irq_o),
    .en_q       (en_q),
    .soft_q     (soft_q),
    .svc_state  (svc_state),
    .svc_lvl    (svc_lvl),
    .win_lvl    (win_lvl)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // Reference model state
    logic [31:0] m_en = '0, m_cls = '0, m_soft = '0, m_def = '0;
    logic        m_sen [16];
    logic [4:0]  m_ssrc[16];
    logic [31:0] m_sadr[16];
    logic        m_act = 1'b0;
    int          m_lvl = 17;
    logic [31:0] m_vadr = '0;

    function automatic logic [31:0] m_norm();
        return (irq_src | m_soft) & m_en & ~m_cls;
    endfunction

    function automatic logic m_fiq();
        return |((irq_src | m_soft) & m_en & m_cls);
    endfunction

    function automatic int m_win();
        logic [31:0] nm = m_norm();
        logic [31:0] bound = '0;
        for (int i = 0; i < 16; i++) if (m_sen[i]) bound[m_ssrc[i]] = 1'b1;
        for (int i = 0; i < 16; i++) if (m_sen[i] && nm[m_ssrc[i]]) return i;
        if ((nm & ~bound) != 0) return 16;
        return 17;
    endfunction

    function automatic logic m_irq();
        return m_win() < (m_act ? m_lvl : 17);
    endfunction

    function automatic logic [31:0] m_addr_of(input int lvl);
        return (lvl < 16) ? m_sadr[lvl] : m_def;
    endfunction

    function automatic logic [31:0] m_vec();
        if (m_irq()) return m_addr_of(m_win());
        return m_act ? m_vadr : m_def;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            8'h03: m_cls = d;
            8'h04: m_en = m_en | d;
            8'h05: m_en = m_en & ~d;
            8'h06: m_soft = m_soft | d;
            8'h07: m_soft = m_soft & ~d;
            8'h08: m_act = 1'b0;
            8'h09: m_def = d;
            default: begin
                if (a >= 8'h40 && a < 8'h50) m_sadr[a - 8'h40] = d;
                if (a >= 8'h80 && a < 8'h90) begin
                    m_sen[a - 8'h80]  = d[5];
                    m_ssrc[a - 8'h80] = d[4:0];
                end
            end
        endcase
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        int w;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        if (a == 8'h08 && m_irq()) begin
            w = m_win();
            m_act = 1'b1; m_lvl = w; m_vadr = m_addr_of(w);
        end
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        irq_src = v;
    endtask

    task automatic chk_out(input string req);
        #1;
        chk({req, " irq_o"}, {31'd0, irq_o}, {31'd0, m_irq()});
        chk({req, " fiq_o"}, {31'd0, fiq_o}, {31'd0, m_fiq()});
    endtask

    task automatic chk_vec(input string req);
        logic [31:0] exp, got;
        exp = m_vec();
        bus_read(8'h08, got);
        chk({req, " vector"}, got, exp);
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] got;
        bus_read(a, got);
        chk(req, got, exp);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            m_sen[i] = 1'b0; m_ssrc[i] = '0; m_sadr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_out("R1");
        chk_reg("R1 enable", 8'h04, 32'h0);
        chk_reg("R1 raw", 8'h00, 32'h0);
        chk_vec("R1");

        // R6: slot and default configuration with read-back
        bus_write(8'h09, 32'hD000_0000);
        bus_write(8'h40, 32'hA000_0000); bus_write(8'h80, 32'h20 | 7);
        bus_write(8'h43, 32'hA300_0000); bus_write(8'h83, 32'h20 | 2);
        bus_write(8'h45, 32'hA500_0000); bus_write(8'h85, 32'h20 | 12);
        chk_reg("R6 ctrl3", 8'h83, 32'h22);
        chk_reg("R6 addr5", 8'h45, 32'hA500_0000);
        chk_reg("R6 default", 8'h09, 32'hD000_0000);

        // R3: enable set/clear
        bus_write(8'h04, 32'h0010_1084);
        bus_write(8'h05, 32'h0010_0000);
        chk_reg("R3 after clear", 8'h05, 32'h0000_1084);
        bus_write(8'h04, 32'h0010_0000);
        chk_reg("R3 after set", 8'h04, 32'h0010_1084);

        // R3: disabled source has no effect
        set_src(32'h0200_0000);
        chk_out("R3 disabled");
        chk_reg("R3 norm status", 8'h01, 32'h0);

        // R2: raw and masked status
        set_src(32'h4000_0004);
        chk_reg("R2 raw", 8'h00, 32'h4000_0004);
        chk_reg("R2 norm", 8'h01, 32'h0000_0004);

        // R7: simultaneous slot requests, slot 0 wins
        set_src(32'h0000_1084);
        chk_out("R9 idle pending");
        chk_vec("R7 lowest slot");
        chk_out("R10 nothing higher");
        chk_vec("R10 recorded address");

        // R11: ack with nonzero data, level request reappears
        bus_write(8'h08, 32'h1234_5678);
        chk_out("R11 reappears");
        chk_vec("R11 again slot0");
        set_src(32'h0000_1004);
        bus_write(8'h08, 32'h0);
        chk_vec("R7 next slot3");
        // R10: pre-emption by higher, not by lower
        chk_out("R10 lower blocked");
        set_src(32'h0000_1084);
        chk_out("R10 higher raises");
        bus_write(8'h08, 32'h0);

        // R8: default-only request
        set_src(32'h0010_0000);
        chk_out("R8 default pending");
        chk_vec("R8 default address");
        set_src(32'h0010_0004);
        chk_out("R10 slot over default service");
        bus_write(8'h08, 32'h0);
        chk_vec("R8 slot beats default");
        bus_write(8'h08, 32'h0);

        // R4: fast class independent of normal path
        bus_write(8'h03, 32'h0000_1000);
        set_src(32'h0000_1004);
        chk_out("R4 both outputs");
        chk_reg("R4 fast status", 8'h02, 32'h0000_1000);
        chk_vec("R4 normal only");
        chk_out("R4 fiq during service");
        bus_write(8'h08, 32'h0);
        chk_out("R4 fiq after ack");

        // R5: software set and clear
        set_src(32'h0);
        bus_write(8'h06, 32'h0010_0000);
        chk_reg("R5 soft raw", 8'h00, 32'h0010_0000);
        chk_out("R5 soft raises");
        bus_write(8'h07, 32'h0);
        chk_reg("R5 zero write no effect", 8'h06, 32'h0010_0000);
        bus_write(8'h07, 32'h0010_0000);
        chk_reg("R5 cleared", 8'h07, 32'h0);
        chk_out("R5 no request");

        // Random phase
        for (int it = 0; it < 500; it++) begin
            int op = $urandom_range(0, 9);
            case (op)
                0, 1: set_src($urandom & $urandom & $urandom);
                2: bus_write(8'h06, $urandom & $urandom & $urandom);
                3: bus_write(8'h07, $urandom);
                4: bus_write(8'h04, $urandom & $urandom);
                5: bus_write(8'h05, $urandom & $urandom & $urandom);
                6: begin
                    int s = $urandom_range(0, 15);
                    bus_write(8'h80 + 8'(s), {26'd0, 1'($urandom), 5'($urandom)});
                    bus_write(8'h40 + 8'(s), $urandom);
                end
                7: bus_write(8'h03, $urandom & $urandom & $urandom & $urandom);
                8: chk_vec("R7 R8 R10 random");
                default: bus_write(8'h08, $urandom);
            endcase
            chk_out("R9 R4 random");
            if (op == 2 || op == 3) chk_reg("R5 random soft", 8'h06, m_soft);
            if (op == 0) chk_reg("R2 random norm", 8'h01, m_norm());
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule